// File: doc/BRIEF.md
# Sticky Alarm Status and Interrupt Controller

This block gathers single-cycle event pulses from a set of converter health monitors (FIFO pointer proximity, clock loss, PLL lock, input pattern and parity checkers) and latches each into a sticky status bit. Two extra status bits summarise groups of events: one for any FIFO pointer proximity event and one for either clock loss. A host reads the bits through a small register port and clears them by writing zeros.

A mask register picks which status bits drive an active-high interrupt line. A control register can arm an automatic shut-off of the transmit output. It can be armed for the clock-loss alarms, for the FIFO pointer collision alarm, or for both. While a qualifying alarm is latched, the gated output enable stays low whatever the pin and software transmit enables say.

Top module: `alarm_ctrl`

## Requirements
- R1: After reset the status register reads 0, the mask register reads all ones (0x1FFF), the shut-off control reads 0, irq_o is low, and out_en_o follows txen_pin_i AND txen_sw_i.
- R2: A pulse on evt_i[k] sets its own status bit on the next clock edge. The event-to-status mapping is: 0 to 0 (write pointer all zeros), 1 to 2 (pointers two apart), 2 to 3 (one apart), 3 to 4 (collision), 4 to 6 (conversion clock lost), 5 to 7 (data clock lost), 6 to 8 (pattern mismatch), 7 to 9 (PLL unlock), 8 to 10 (rising-edge parity), 9 to 11 (falling-edge parity), 10 to 12 (block parity).
- R3: A set status bit stays set with no further events. Writes to the mask or control registers do not disturb it.
- R4: Writing to address 0 clears each status bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. Writing ones never sets a bit.
- R5: If an event arrives in the same cycle as a host clear of its bit, the bit ends up set.
- R6: Status bit 1 (FIFO summary) sets on any of events 1, 2 or 3.
- R7: Status bit 5 (clock summary) sets on event 4 or event 5, together with that clock's own bit.
- R8: irq_o is a register holding the OR of (status AND NOT mask), where mask bit 1 means suppressed. It rises on the edge after the status bit sets, and it falls on the edge after the contributing bits are cleared or masked.
- R9: Control register (address 2) bit 0 arms shut-off on status bits 5, 6 and 7. Bit 1 arms it on status bit 4. While an armed qualifying bit is set, out_en_o is 0 regardless of both transmit enables.
- R10: With no armed qualifying bit set, out_en_o = txen_pin_i AND txen_sw_i. The output enable recovers in the same cycle the qualifying bits are cleared. Non-qualifying alarms never gate it.
- R11: A read strobe at address 0 (status), 1 (mask) or 2 (control) presents that register on rdata_o after the next edge. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 11 | Single-cycle alarm event pulses |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 13 | Register write data |
| rdata_o | output | 13 | Registered read data |
| txen_pin_i | input | 1 | Transmit enable from pin |
| txen_sw_i | input | 1 | Transmit enable from software |
| irq_o | output | 1 | Interrupt, active high |
| out_en_o | output | 1 | Gated transmit output enable |

## Verification
The bench drives an event on the same edge as a clear of its own bit. A design where the clear wins would lose that alarm. It checks interrupt timing cycle by cycle, so an unregistered interrupt or one lagging an extra cycle shows up as a mismatch at the first sample. It also writes all ones to a cleared status register to catch a design that sets bits from write data. It sets non-qualifying FIFO alarms with shut-off armed, to catch a gate wired to the FIFO summary instead of the collision bit.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int EVT_N  = 11;
  localparam int STAT_N = 13;
  localparam int DATA_W = STAT_N;
  localparam int ADDR_W = 2;

  // status bit positions
  localparam int S_ZERO   = 0;
  localparam int S_FIFO   = 1;
  localparam int S_NEAR2  = 2;
  localparam int S_NEAR1  = 3;
  localparam int S_COLL   = 4;
  localparam int S_CLK    = 5;
  localparam int S_CLKA   = 6;
  localparam int S_CLKB   = 7;
  localparam int S_PAT    = 8;
  localparam int S_PLL    = 9;
  localparam int S_PRISE  = 10;
  localparam int S_PFALL  = 11;
  localparam int S_PBLK   = 12;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_CTL    = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic coll_off;
    logic clk_off;
  } ctl_t;
endpackage

// File: rtl/alarm_status.sv
module alarm_status
  import alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_N-1:0] status_o
);
  logic [STAT_N-1:0] set_vec, clr_vec, status_q;

  // event k maps to status bit k (k=0) or k+1 (k=1..3) or k+2 (k>=4)
  always_comb begin
    set_vec = '0;
    for (int k = 0; k < EVT_N; k++) begin
      if (k == 0)     set_vec[k]   = evt_i[k];
      else if (k < 4) set_vec[k+1] = evt_i[k];
      else            set_vec[k+2] = evt_i[k];
    end
    set_vec[S_FIFO] = |evt_i[3:1];
    set_vec[S_CLK]  = |evt_i[5:4];
  end

  assign clr_vec = clr_en_i ? ~wdata_i[STAT_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_vec) | set_vec;  // set wins
  end

  assign status_o = status_q;

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/alarm_cfg.sv
module alarm_cfg
  import alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [STAT_N-1:0] mask_o,
  output ctl_t              ctl_o
);
  logic [STAT_N-1:0] mask_q;
  ctl_t              ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ctl_q  <= '0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i[STAT_N-1:0];
      if (ctl_we_i)  ctl_q  <= ctl_t'(wdata_i[1:0]);
    end
  end

  assign mask_o = mask_q;
  assign ctl_o  = ctl_q;
endmodule

// File: rtl/alarm_irq_gate.sv
module alarm_irq_gate
  import alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_N-1:0] status_i,
  input  logic [STAT_N-1:0] mask_i,
  input  ctl_t              ctl_i,
  input  logic              txen_pin_i,
  input  logic              txen_sw_i,
  output logic              irq_o,
  output logic              out_en_o
);
  logic irq_q, shut;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & ~mask_i);
  end

  assign shut = (ctl_i.clk_off  & (status_i[S_CLK] | status_i[S_CLKA] | status_i[S_CLKB]))
              | (ctl_i.coll_off & status_i[S_COLL]);

  assign irq_o    = irq_q;
  assign out_en_o = txen_pin_i & txen_sw_i & ~shut;

  a_r8_irq_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status_i & ~mask_i))));
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              txen_pin_i,
  input  logic              txen_sw_i,
  output logic              irq_o,
  output logic              out_en_o
);
  logic [STAT_N-1:0] status, mask;
  ctl_t              ctl;
  logic [DATA_W-1:0] rdata_q, rsel;
  reg_addr_e         addr;

  assign addr = reg_addr_e'(addr_i);

  alarm_status u_status (
    .clk_i, .rst_ni, .evt_i,
    .clr_en_i (wr_en_i && addr == A_STATUS),
    .wdata_i,
    .status_o (status)
  );

  alarm_cfg u_cfg (
    .clk_i, .rst_ni,
    .mask_we_i (wr_en_i && addr == A_MASK),
    .ctl_we_i  (wr_en_i && addr == A_CTL),
    .wdata_i,
    .mask_o    (mask),
    .ctl_o     (ctl)
  );

  alarm_irq_gate u_gate (
    .clk_i, .rst_ni,
    .status_i (status),
    .mask_i   (mask),
    .ctl_i    (ctl),
    .txen_pin_i, .txen_sw_i,
    .irq_o, .out_en_o
  );

  always_comb begin
    unique case (addr)
      A_STATUS: rsel = DATA_W'(status);
      A_MASK:   rsel = DATA_W'(mask);
      A_CTL:    rsel = DATA_W'(ctl);
      default:  rsel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rsel;
  end

  assign rdata_o = rdata_q;

  a_r9_clk_shutoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl.clk_off && status[S_CLK]) |-> !out_en_o);

  a_r9_coll_shutoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl.coll_off && status[S_COLL]) |-> !out_en_o);
endmodule

// File: tb/alarm_ctrl_test.sv
module alarm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int EN = 11;
  localparam int SN = 13;

  logic clk = 0, rst_n = 0;
  logic [EN-1:0] evt = '0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [SN-1:0] wdata = '0, rdata;
  logic txen_pin = 1, txen_sw = 1;
  logic irq, out_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .txen_pin_i(txen_pin),
    .txen_sw_i(txen_sw), .irq_o(irq), .out_en_o(out_en)
  );

  function automatic logic [SN-1:0] map_evt(int k);
    logic [SN-1:0] m = '0;
    if (k == 0) m[0] = 1;
    else if (k < 4) begin m[k+1] = 1; m[1] = 1; end
    else begin m[k+2] = 1; if (k < 6) m[5] = 1; end
    return m;
  endfunction

  task automatic check(string req, logic [SN-1:0] act, logic [SN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [1:0] a, logic [SN-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic reg_rd(logic [1:0] a, output logic [SN-1:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse(logic [EN-1:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    logic [SN-1:0] d;
    reg_rd(2'd0, d); check("R1 status", d, '0);
    reg_rd(2'd1, d); check("R1 mask", d, 13'h1FFF);
    reg_rd(2'd2, d); check("R1 ctl", d, '0);
    check("R1 irq", irq, 0);
    check("R1 out_en", out_en, 1);
  endtask

  task automatic t_each;
    logic [SN-1:0] d;
    for (int k = 0; k < EN; k++) begin
      pulse(EN'(1) << k);
      reg_rd(2'd0, d);
      if (k >= 1 && k <= 3) check("R6 fifo summary", d, map_evt(k));
      else if (k == 4 || k == 5) check("R7 clock summary", d, map_evt(k));
      else check("R2 event map", d, map_evt(k));
      reg_wr(2'd0, '0);
    end
    reg_rd(2'd0, d); check("R4 clear all", d, '0);
  endtask

  task automatic t_sticky;
    logic [SN-1:0] d;
    pulse(EN'(1) << 7);
    repeat (5) @(negedge clk);
    reg_wr(2'd1, 13'h1FFF);
    reg_wr(2'd2, '0);
    reg_rd(2'd0, d); check("R3 sticky", d, 13'h0200);
    reg_wr(2'd0, '0);
  endtask

  task automatic t_clear_sel;
    logic [SN-1:0] d;
    reg_wr(2'd0, 13'h1FFF);
    reg_rd(2'd0, d); check("R4 write ones no set", d, '0);
    pulse((EN'(1) << 7) | (EN'(1) << 6));
    reg_wr(2'd0, 13'h0200);
    reg_rd(2'd0, d); check("R4 selective clear", d, 13'h0200);
    reg_wr(2'd0, '0);
  endtask

  task automatic t_set_wins;
    logic [SN-1:0] d;
    pulse(EN'(1) << 8);
    @(negedge clk); evt = EN'(1) << 8; wr_en = 1; addr = 2'd0; wdata = '0;
    @(negedge clk); evt = '0; wr_en = 0;
    reg_rd(2'd0, d); check("R5 set beats clear", d, 13'h0400);
    reg_wr(2'd0, '0);
  endtask

  task automatic t_irq;
    pulse(EN'(1) << 9);
    @(negedge clk); check("R8 masked no irq", irq, 0);
    reg_wr(2'd1, ~13'h0800);          // mask written at edge, irq one edge later
    check("R8 not yet", irq, 0);
    @(negedge clk); check("R8 unmasked irq", irq, 1);
    reg_wr(2'd0, '0);
    @(negedge clk); check("R8 irq drops", irq, 0);
    reg_wr(2'd1, ~13'h0200);
    @(negedge clk); evt = EN'(1) << 7;
    @(negedge clk); evt = '0; check("R8 irq lag cycle", irq, 0);
    @(negedge clk); check("R8 irq rises", irq, 1);
    reg_wr(2'd0, '0);
    reg_wr(2'd1, 13'h1FFF);
  endtask

  task automatic t_shutoff;
    reg_wr(2'd2, 13'h1);
    @(negedge clk); evt = EN'(1) << 5;
    @(negedge clk); evt = '0; check("R9 clk shutoff", out_en, 0);
    reg_wr(2'd0, '0);
    check("R10 recover", out_en, 1);
    reg_wr(2'd2, 13'h2);
    pulse(EN'(1) << 2);
    check("R10 near1 no gate", out_en, 1);
    pulse(EN'(1) << 4);
    check("R10 clock not armed", out_en, 1);
    pulse(EN'(1) << 3);
    check("R9 coll shutoff", out_en, 0);
    txen_pin = 0; txen_sw = 1; #1 check("R9 pin low still off", out_en, 0);
    reg_wr(2'd2, '0);
    check("R10 disarmed pin low", out_en, 0);
    txen_pin = 1; #1 check("R10 disarmed on", out_en, 1);
    txen_sw = 0; #1 check("R10 sw low", out_en, 0);
    txen_sw = 1;
    reg_wr(2'd0, '0);
  endtask

  task automatic t_addr;
    logic [SN-1:0] d;
    pulse(EN'(1) << 0);
    reg_rd(2'd3, d); check("R11 unmapped", d, '0);
    reg_wr(2'd2, 13'h3);
    reg_rd(2'd2, d); check("R11 ctl read", d, 13'h3);
    reg_wr(2'd0, '0);
    reg_wr(2'd2, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_each();
    t_sticky();
    t_clear_sel();
    t_set_wins();
    t_irq();
    t_shutoff();
    t_addr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule